// File: doc/BRIEF.md
# Streaming 3x3 Prewitt Edge Magnitude

This block takes a raster-ordered stream of 8-bit pixels, one per accepted cycle, for an image whose row length is fixed at elaboration. Two row-length line stores give access to the two rows above the arriving pixel, so every arriving pixel completes one column of a 3x3 neighbourhood. A horizontal and a vertical Prewitt gradient are formed on that neighbourhood. Their squared sum then passes through a pipelined integer square root, giving the edge strength of the window's centre pixel.

Gradient work is done per column rather than per window. Each arriving column is reduced at once to a column total and a top-minus-bottom difference. The three most recent reductions are kept in registers and used again as the window slides right. The horizontal gradient is then one subtraction and the vertical gradient one three-term addition. Only windows lying wholly inside the image produce results, so an image of R rows and C columns gives (R-2) by (C-2) magnitudes. Both sides use a valid/ready handshake. When the consumer stalls, the entire pipeline freezes and no pixel is lost.

Top module: `prewitt_mag_stream`

## Requirements
- R1: `in_ready` is low in every cycle where `out_valid` is high and `out_ready` is low, and high in every other cycle.
- R2: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with `out_mag` unchanged.
- R3: An image of R rows by IMG_W columns yields exactly (R-2)*(IMG_W-2) outputs in raster order of their window centres, and no output beyond those.
- R4: After reset, no output appears before 2*IMG_W+3 pixels have been accepted.
- R5: Window centres are limited to columns 1 to IMG_W-2 of rows 1 to R-2, so no emitted window mixes pixels from the end of one row with the start of the next.
- R6: Each output equals floor(sqrt(Gx*Gx + Gy*Gy)). Gx is the sum of the window's right column minus the sum of its left column. Gy is the sum of its top row minus the sum of its bottom row.
- R7: The root is truncated toward zero: for energy E and result r, r*r <= E < (r+1)*(r+1), with E held in 22 bits and r in 11 bits.
- R8: A vertical step from 0 on the left to 255 on the right gives 765 for windows that straddle it, and 0 for windows on either flat side.
- R9: During reset `out_valid` is low and `in_ready` is high.
- R10: Random output back-pressure and random gaps on `in_valid` together leave the output sequence identical to an unstalled run.
- R11: A uniform image gives magnitude 0 for every window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A pixel is offered on `in_pix` |
| in_ready | output | 1 | The block takes the offered pixel this cycle |
| in_pix | input | PIX_W | Unsigned pixel value, raster order |
| out_valid | output | 1 | `out_mag` holds a result |
| out_ready | input | 1 | The consumer takes the result this cycle |
| out_mag | output | PIX_W+3 | Edge magnitude of the current window centre |

## Verification
The bench builds the block with 8-bit pixels and a row length of 8. With that short row, the startup threshold of 19 accepted pixels and the end-of-row exclusion are reached within a few dozen pixels. A six-row image then exercises four full output rows, each with its first and last columns dropped. The 8-bit width keeps full-scale gradients at 765, so exact expected roots, including truncated non-square energies, can be worked out in the bench. The same geometry is run with random stalls and input gaps to show that the stall path preserves order.

// File: rtl/prewitt_pkg.sv
package prewitt_pkg;

   // progress of the row counter since reset
   typedef enum logic [1:0] {
      ROW_FIRST  = 2'd0,
      ROW_SECOND = 2'd1,
      ROW_FULL   = 2'd2
   } row_phase_e;

   // column total of three pixels
   function automatic int sum_width(input int pix_w);
      return pix_w + 2;
   endfunction

   // signed top-minus-bottom difference of one column
   function automatic int dif_width(input int pix_w);
      return pix_w + 1;
   endfunction

   // signed gradient, magnitude up to 3*(2**pix_w-1)
   function automatic int grad_width(input int pix_w);
      return pix_w + 3;
   endfunction

   function automatic int energy_width(input int pix_w);
      return 2 * (pix_w + 3);
   endfunction

endpackage

// File: rtl/pm_window.sv
module pm_window
   import prewitt_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int IMG_W = 64,
   localparam int SUM_W = sum_width(PIX_W),
   localparam int DIF_W = dif_width(PIX_W)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        take,
   input  logic [PIX_W-1:0]            pix,
   output logic                        win_ok,
   output logic [2:0][SUM_W-1:0]       sum_q,
   output logic [2:0][DIF_W-1:0]       dif_q
);

   localparam int LINES = 2;
   localparam int COL_W = (IMG_W > 1) ? $clog2(IMG_W) : 1;

   if (IMG_W < 3) begin : g_bad_width
      $error("pm_window: IMG_W must be at least 3");
   end
   if (PIX_W < 2) begin : g_bad_pix
      $error("pm_window: PIX_W must be at least 2");
   end

   logic [COL_W-1:0]             col;
   row_phase_e                   phase;
   logic [LINES-1:0][PIX_W-1:0]  tap;

   // line stores: store 0 holds the row above, store 1 the row two above
   for (genvar g = 0; g < LINES; g++) begin : g_line
      logic [PIX_W-1:0] mem [IMG_W];
      logic [PIX_W-1:0] feed;
      if (g == 0) begin : g_head
         assign feed = pix;
      end else begin : g_chain
         assign feed = tap[g-1];
      end
      always_ff @(posedge clk) begin
         if (take) mem[col] <= feed;
      end
      assign tap[g] = mem[col];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         col   <= '0;
         phase <= ROW_FIRST;
      end else if (take) begin
         if (col == COL_W'(IMG_W - 1)) begin
            col <= '0;
            case (phase)
               ROW_FIRST:  phase <= ROW_SECOND;
               ROW_SECOND: phase <= ROW_FULL;
               default:    phase <= ROW_FULL;
            endcase
         end else begin
            col <= col + 1'b1;
         end
      end
   end

   // window ending at this pixel lies wholly inside the current rows
   assign win_ok = (phase == ROW_FULL) && (col >= COL_W'(2));

   logic [PIX_W-1:0] px_top, px_mid;
   logic [SUM_W-1:0] sum_new;
   logic [DIF_W-1:0] dif_new;

   always_comb begin
      px_top  = tap[1];
      px_mid  = tap[0];
      sum_new = SUM_W'(px_top) + SUM_W'(px_mid) + SUM_W'(pix);
      dif_new = DIF_W'(px_top) - DIF_W'(pix);
   end

   // column reductions slide left; index 0 is the oldest (left) column
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q <= '0;
         dif_q <= '0;
      end else if (take) begin
         sum_q <= {sum_new, sum_q[2], sum_q[1]};
         dif_q <= {dif_new, dif_q[2], dif_q[1]};
      end
   end

endmodule

// File: rtl/pm_energy.sv
module pm_energy
   import prewitt_pkg::*;
#(
   parameter int PIX_W = 8,
   localparam int SUM_W  = sum_width(PIX_W),
   localparam int DIF_W  = dif_width(PIX_W),
   localparam int GRAD_W = grad_width(PIX_W),
   localparam int ENG_W  = energy_width(PIX_W)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   en,
   input  logic                   v_in,
   input  logic [2:0][SUM_W-1:0]  sum_q,
   input  logic [2:0][DIF_W-1:0]  dif_q,
   output logic                   v_out,
   output logic [ENG_W-1:0]       energy
);

   localparam longint FULL   = 3 * ((longint'(1) << PIX_W) - 1);
   localparam longint ENG_MAX = 2 * FULL * FULL;

   logic signed [GRAD_W-1:0] gx_c, gy_c, gx_q, gy_q;
   logic                     v_mid;
   logic signed [ENG_W-1:0]  gx_e, gy_e, sq_sum;

   always_comb begin
      gx_c = $signed({1'b0, sum_q[2]}) - $signed({1'b0, sum_q[0]});
      gy_c = $signed({{2{dif_q[0][DIF_W-1]}}, dif_q[0]})
           + $signed({{2{dif_q[1][DIF_W-1]}}, dif_q[1]})
           + $signed({{2{dif_q[2][DIF_W-1]}}, dif_q[2]});
      gx_e   = $signed({{GRAD_W{gx_q[GRAD_W-1]}}, gx_q});
      gy_e   = $signed({{GRAD_W{gy_q[GRAD_W-1]}}, gy_q});
      sq_sum = gx_e * gx_e + gy_e * gy_e;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_mid  <= 1'b0;
         gx_q   <= '0;
         gy_q   <= '0;
         v_out  <= 1'b0;
         energy <= '0;
      end else if (en) begin
         v_mid  <= v_in;
         gx_q   <= gx_c;
         gy_q   <= gy_c;
         v_out  <= v_mid;
         energy <= $unsigned(sq_sum);
      end
   end

   // R6: energy of a valid window never exceeds the two full-scale squares
   p_energy_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      v_out |-> (longint'(energy) <= ENG_MAX));

endmodule

// File: rtl/pm_isqrt.sv
module pm_isqrt #(
   parameter int OP_W = 22,
   localparam int RT_W = OP_W / 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             v_in,
   input  logic [OP_W-1:0]  op_in,
   output logic             v_out,
   output logic [RT_W-1:0]  root
);

   if ((OP_W % 2) != 0 || OP_W < 4) begin : g_bad_op
      $error("pm_isqrt: OP_W must be even and at least 4");
   end

   logic [RT_W-1:0]            v_q;
   logic [RT_W-1:0][OP_W-1:0]  op_q;
   logic [RT_W-1:0][RT_W-1:0]  rt_q;

   logic [RT_W-1:0]            cur_v;
   logic [RT_W-1:0][OP_W-1:0]  cur_op;
   logic [RT_W-1:0][RT_W-1:0]  cur_rt;
   logic [RT_W-1:0][RT_W-1:0]  trial;
   logic [RT_W-1:0][OP_W-1:0]  tsq;
   logic [RT_W-1:0]            keep;

   // stage i settles root bit RT_W-1-i by a trial-square compare
   always_comb begin
      for (int i = 0; i < RT_W; i++) begin
         if (i == 0) begin
            cur_v[i]  = v_in;
            cur_op[i] = op_in;
            cur_rt[i] = '0;
         end else begin
            cur_v[i]  = v_q[i-1];
            cur_op[i] = op_q[i-1];
            cur_rt[i] = rt_q[i-1];
         end
         trial[i] = cur_rt[i] | (RT_W'(1) << (RT_W - 1 - i));
         tsq[i]   = OP_W'(trial[i]) * OP_W'(trial[i]);
         keep[i]  = (tsq[i] <= cur_op[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q  <= '0;
         op_q <= '0;
         rt_q <= '0;
      end else if (en) begin
         for (int i = 0; i < RT_W; i++) begin
            v_q[i]  <= cur_v[i];
            op_q[i] <= cur_op[i];
            rt_q[i] <= keep[i] ? trial[i] : cur_rt[i];
         end
      end
   end

   assign v_out = v_q[RT_W-1];
   assign root  = rt_q[RT_W-1];

   // R7: result is the floor of the square root of the operand it travelled with
   p_root_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      v_out |-> (((OP_W+2)'(root) * (OP_W+2)'(root)) <= (OP_W+2)'(op_q[RT_W-1]))
             && ((((OP_W+2)'(root) + 1) * ((OP_W+2)'(root) + 1)) > (OP_W+2)'(op_q[RT_W-1])));

endmodule

// File: rtl/prewitt_mag_stream.sv
module prewitt_mag_stream
   import prewitt_pkg::*;
#(
   parameter int PIX_W = 8,
   parameter int IMG_W = 64,
   localparam int SUM_W = sum_width(PIX_W),
   localparam int DIF_W = dif_width(PIX_W),
   localparam int ENG_W = energy_width(PIX_W),
   localparam int MAG_W = ENG_W / 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [PIX_W-1:0]  in_pix,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [MAG_W-1:0]  out_mag
);

   logic                  adv, take, win_ok, win_v, eng_v;
   logic [2:0][SUM_W-1:0] sum_q;
   logic [2:0][DIF_W-1:0] dif_q;
   logic [ENG_W-1:0]      energy;

   // whole pipeline moves only when the last stage is empty or drained
   assign adv      = !out_valid || out_ready;
   assign in_ready = adv;
   assign take     = in_valid && adv;

   pm_window #(.PIX_W(PIX_W), .IMG_W(IMG_W)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (take),
      .pix    (in_pix),
      .win_ok (win_ok),
      .sum_q  (sum_q),
      .dif_q  (dif_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)   win_v <= 1'b0;
      else if (adv) win_v <= take && win_ok;
   end

   pm_energy #(.PIX_W(PIX_W)) u_energy (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (adv),
      .v_in   (win_v),
      .sum_q  (sum_q),
      .dif_q  (dif_q),
      .v_out  (eng_v),
      .energy (energy)
   );

   pm_isqrt #(.OP_W(ENG_W)) u_isqrt (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv),
      .v_in  (eng_v),
      .op_in (energy),
      .v_out (out_valid),
      .root  (out_mag)
   );

   // saturating count of accepted pixels, for the startup check
   localparam int FIRST_OUT = 2 * IMG_W + 3;
   localparam int SEEN_W    = $clog2(FIRST_OUT + 1);
   logic [SEEN_W-1:0] seen;

   always_ff @(posedge clk) begin
      if (!rst_n) seen <= '0;
      else if (take && (seen != SEEN_W'(FIRST_OUT))) seen <= seen + 1'b1;
   end

   // R1: a held result blocks the input side
   p_stall_in_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R2: a result that was not taken stays put
   p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_mag)));

   // R4: no result before two rows and three pixels have arrived
   p_startup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (seen == SEEN_W'(FIRST_OUT)));

endmodule

// File: tb/sim_prewitt_mag_stream.sv
module sim_prewitt_mag_stream;

   localparam int P    = 8;
   localparam int W    = 8;
   localparam int MAGW = 2 * (P + 3) / 2;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            in_valid;
   logic            in_ready;
   logic [P-1:0]    in_pix;
   logic            out_valid;
   logic            out_ready;
   logic [MAGW-1:0] out_mag;

   int n_chk = 0;
   int n_bad = 0;
   int img   [0:63];
   int exp_a [0:63];
   int n_exp;
   logic [15:0] lfsr = 16'hACE1;

   always #5 clk = ~clk;

   prewitt_mag_stream #(.PIX_W(P), .IMG_W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready), .out_mag(out_mag)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int pix_of(input int pat, input int r, input int c);
      case (pat)
         0: return (r * 37 + c * 23 + r * c * 11) & 255;
         1: return 90;
         2: return (c >= 4) ? 255 : 0;
         3: return ((r * 131 + c * 71) ^ (r * c * 29)) & 255;
         default: return (c == 0 || c == W - 1) ? 250 : 5;
      endcase
   endfunction

   function automatic int floor_root(input int e);
      int rt = 0;
      while ((rt + 1) * (rt + 1) <= e) rt++;
      return rt;
   endfunction

   task automatic build(input int pat, input int rows);
      n_exp = 0;
      for (int r = 0; r < rows; r++)
         for (int c = 0; c < W; c++) img[r * W + c] = pix_of(pat, r, c);
      for (int r = 1; r < rows - 1; r++) begin
         for (int c = 1; c < W - 1; c++) begin
            int gx = 0;
            int gy = 0;
            for (int k = -1; k <= 1; k++) begin
               gx += img[(r + k) * W + c + 1] - img[(r + k) * W + c - 1];
               gy += img[(r - 1) * W + c + k] - img[(r + 1) * W + c + k];
            end
            exp_a[n_exp] = floor_root(gx * gx + gy * gy);
            n_exp++;
         end
      end
   endtask

   task automatic do_reset();
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_pix    = '0;
      out_ready = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 1'b0, "R9 out_valid in reset", int'(out_valid), 0);
      chk(in_ready == 1'b1, "R9 in_ready in reset", int'(in_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // stream one image, optionally with stalls and input gaps
   task automatic run_image(input int pat, input int rows, input bit bp,
                            input bit gaps, input string req, input string cnt_req);
      int  idx = 0;
      int  got = 0;
      int  cyc = 0;
      bit  first = 1'b1;
      bit  held_v = 1'b0;
      int  held = 0;
      int  n_pix = rows * W;
      do_reset();
      build(pat, rows);
      while ((idx < n_pix || got < n_exp) && cyc < 3000) begin
         @(negedge clk);
         cyc++;
         lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         out_ready = bp ? (lfsr[0] | lfsr[3]) : 1'b1;
         in_valid  = (idx < n_pix) && !(gaps && lfsr[5] && lfsr[7]);
         in_pix    = (idx < n_pix) ? P'(img[idx]) : '0;
         #1;
         if (held_v)
            chk(out_valid && (int'(out_mag) == held), "R2 held result", int'(out_mag), held);
         if (out_valid && !out_ready)
            chk(in_ready == 1'b0, "R1 ready while stalled", int'(in_ready), 0);
         else
            chk(in_ready == 1'b1, "R1 ready while free", int'(in_ready), 1);
         held_v = out_valid && !out_ready;
         held   = int'(out_mag);
         if (out_valid && first) begin
            first = 1'b0;
            chk(idx >= 2 * W + 3, "R4 pixels before first output", idx, 2 * W + 3);
         end
         if (in_valid && in_ready) idx++;
         if (out_valid && out_ready) begin
            if (got < n_exp)
               chk(int'(out_mag) == exp_a[got], req, int'(out_mag), exp_a[got]);
            else
               chk(1'b0, "R3 extra output", got + 1, n_exp);
            got++;
         end
      end
      in_valid  = 1'b0;
      out_ready = 1'b1;
      repeat (30) begin
         @(negedge clk);
         #1;
         if (out_valid) got++;
      end
      chk(got == n_exp, cnt_req, got, n_exp);
   endtask

   task automatic t_ramp();
      run_image(0, 6, 1'b0, 1'b0, "R6 ramp magnitude", "R3 output count");
   endtask

   task automatic t_step();
      run_image(2, 4, 1'b0, 1'b0, "R8 step magnitude", "R3 output count step");
      chk(exp_a[2] == 765, "R8 reference straddle value", exp_a[2], 765);
   endtask

   task automatic t_flat();
      run_image(1, 5, 1'b0, 1'b0, "R11 uniform magnitude", "R3 output count flat");
   endtask

   task automatic t_row_ends();
      run_image(4, 5, 1'b0, 1'b0, "R5 row end windows", "R5 output count");
   endtask

   task automatic t_stalls();
      run_image(3, 6, 1'b1, 1'b1, "R7 truncated root under stalls", "R10 output count");
      run_image(0, 6, 1'b1, 1'b0, "R10 ramp under stalls", "R10 output count ramp");
   endtask

   initial begin
      t_ramp();
      t_step();
      t_flat();
      t_row_ends();
      t_stalls();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1_500_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule